// File: doc/BRIEF.md
# Streaming 3x3 Kernel Filter with a Shared Multiply-Accumulate

This block turns a raster stream of 8-bit pixels into filtered pixels, one per complete 3x3 neighbourhood. Each accepted pixel is written into a column-addressed line store. The store holds the two earlier rows, so its depth follows the run-time image width and not a fixed hardware length. The new pixel and the two pixels above it form a column, and that column shifts into a three-column window.

A single signed multiplier and a single adder compute the weighted sum. A sequencer walks a multiplexer over the nine coefficient/pixel pairs, one pair per clock, and accumulates the products. The sum is then shifted right by a programmable amount and saturated to the 0..255 pixel range.

The right-hand column of the window is also driven out. A downstream rank-order sorter can consume it directly.

Top module: `conv3x3_mac`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `out_vld` and `out_pix` are 0.
- R2: For a pixel accepted at row r and column c, the result is the sum over row offset a and column offset b (each 0..2) of coefficient k = 3a+b times the pixel at (r-2+a, c-2+b). Coefficient k occupies `coefs[8k+7:8k]` as a signed two's-complement byte.
- R3: The sum is arithmetically shifted right by `shamt` (0..15). The shifted value is then saturated: negative values give 0, values above 255 give 255, and anything else passes through unchanged.
- R4: The row delay of the window equals `img_width` (3..MAX_W) in accepted pixels. A new width takes effect from the pixel that carries `sof`.
- R5: A result is produced only for pixels with row >= 2 and column >= 2. A frame of H rows and W columns therefore yields exactly (H-2)(W-2) results. The first result comes after two full rows and three pixels of the third row.
- R6: If a qualifying pixel is sampled on clock edge E0, `out_vld` is high for exactly one cycle, the one following edge E9, and is low on every other cycle.
- R7: After each accepted pixel, `sort_col[7:0]` holds that pixel. `sort_col[15:8]` holds the pixel one row above in the same column (for row >= 1), and `sort_col[23:16]` holds the pixel two rows above (for row >= 2).
- R8: A pixel with `sof` high is taken as row 0, column 0, whatever position the previous frame had reached.
- R9: Accepted pixels are at least 9 clocks apart. The environment must keep `pix_vld` low for at least 8 cycles after each accepted pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | Marks the first pixel of a frame |
| pix_vld | input | 1 | Input pixel qualifier |
| pix_in | input | 8 | Input pixel |
| img_width | input | clog2(MAX_W+1) | Pixels per row, 3..MAX_W |
| coefs | input | 72 | Nine signed 8-bit coefficients, k = 3*row + column |
| shamt | input | 4 | Right-shift applied to the sum |
| out_vld | output | 1 | One-cycle result strobe |
| out_pix | output | 8 | Filtered, saturated pixel |
| sort_col | output | 24 | Right-hand window column, newest pixel in the low byte |

## Verification
A wrong line-store address or row delay shows at `sort_col` the cycle after the first pixel of the second row. It also shows in `out_pix` from the first window that follows. A sequencer that skips, repeats or misorders a tap leaves the strobe timing unchanged but moves `out_pix` away from the arithmetic result on the first window with an asymmetric kernel. A bad position counter shows up as a missing or extra strobe in the first three columns of the third row. A strobe off by one cycle is caught nine clocks after the pixel that started the window.

// File: rtl/conv_pkg.sv
package conv_pkg;
    localparam int PIX_W  = 8;
    localparam int COEF_W = 8;
    localparam int ACC_W  = 20;
    localparam int TAPS   = 9;
    localparam int SH_W   = 4;
    localparam int ST_W   = $clog2(TAPS);
    localparam int PROD_W = COEF_W + PIX_W + 1;

    typedef logic [PIX_W-1:0]         pix_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    // one window column; top = oldest row
    typedef struct packed {
        pix_t up2;
        pix_t up1;
        pix_t cur;
    } column_t;

    function automatic pix_t sat_pixel(input acc_t v);
        if (v < 0)
            return '0;
        else if (v > acc_t'((1 << PIX_W) - 1))
            return '1;
        else
            return v[PIX_W-1:0];
    endfunction
endpackage

// File: rtl/conv_linebuf.sv
module conv_linebuf
    import conv_pkg::*;
#(
    parameter int MAX_W = 64,
    localparam int AW = $clog2(MAX_W)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  pix_t          din,
    output column_t       col_out
);
    // each entry keeps the previous two rows of one column
    logic [2*PIX_W-1:0] store [MAX_W];
    logic [2*PIX_W-1:0] rd;

    assign rd = store[addr];

    always_ff @(posedge clk) begin
        if (wr_en)
            store[addr] <= {din, rd[2*PIX_W-1:PIX_W]};
    end

    assign col_out.cur = din;
    assign col_out.up1 = rd[2*PIX_W-1:PIX_W];
    assign col_out.up2 = rd[PIX_W-1:0];
endmodule

// File: rtl/conv_window.sv
module conv_window
    import conv_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        shift_en,
    input  column_t                     col_in,
    output logic [TAPS-1:0][PIX_W-1:0]  taps,
    output column_t                     right_col
);
    column_t cols [3];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 3; i++) cols[i] <= '0;
        end else if (shift_en) begin
            cols[0] <= cols[1];
            cols[1] <= cols[2];
            cols[2] <= col_in;
        end
    end

    for (genvar c = 0; c < 3; c++) begin : g_tap
        assign taps[c]     = cols[c].up2;
        assign taps[3 + c] = cols[c].up1;
        assign taps[6 + c] = cols[c].cur;
    end

    assign right_col = cols[2];
endmodule

// File: rtl/conv_mac.sv
module conv_mac
    import conv_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic [TAPS-1:0][PIX_W-1:0]   taps,
    input  logic [TAPS-1:0][COEF_W-1:0]  coefs,
    input  logic [SH_W-1:0]              shamt,
    output logic                         busy,
    output logic [ST_W-1:0]              step,
    output logic                         out_vld,
    output pix_t                         out_pix
);
    acc_t                       acc;
    acc_t                       sum;
    acc_t                       prod_ext;
    logic signed [COEF_W-1:0]   c_sel;
    logic signed [PIX_W:0]      p_sel;
    logic signed [PROD_W-1:0]   prod;

    // the one multiplier and the one adder, fed through the tap mux
    assign c_sel    = $signed(coefs[step]);
    assign p_sel    = $signed({1'b0, taps[step]});
    assign prod     = c_sel * p_sel;
    assign prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
    assign sum      = acc + prod_ext;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            step    <= '0;
            acc     <= '0;
            out_vld <= 1'b0;
            out_pix <= '0;
        end else begin
            out_vld <= 1'b0;
            if (busy) begin
                acc <= sum;
                if (step == ST_W'(TAPS - 1)) begin
                    busy    <= 1'b0;
                    out_vld <= 1'b1;
                    out_pix <= sat_pixel(sum >>> shamt);
                end else begin
                    step <= step + 1'b1;
                end
            end
            if (start) begin
                busy <= 1'b1;
                step <= '0;
                acc  <= '0;
            end
        end
    end
endmodule

// File: rtl/conv3x3_mac.sv
module conv3x3_mac
    import conv_pkg::*;
#(
    parameter int MAX_W = 64,
    localparam int AW = $clog2(MAX_W),
    localparam int CW = $clog2(MAX_W + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sof,
    input  logic                     pix_vld,
    input  logic [PIX_W-1:0]         pix_in,
    input  logic [CW-1:0]            img_width,
    input  logic [TAPS*COEF_W-1:0]   coefs,
    input  logic [SH_W-1:0]          shamt,
    output logic                     out_vld,
    output logic [PIX_W-1:0]         out_pix,
    output logic [3*PIX_W-1:0]       sort_col
);
    logic [AW-1:0]  col_q, pc;
    logic [1:0]     row_q, pr;
    logic           last_col;
    logic           win_ok;
    column_t        lb_col;
    column_t        right_col;
    logic [TAPS-1:0][PIX_W-1:0]  taps;
    logic [TAPS-1:0][COEF_W-1:0] coef_arr;
    logic           mac_busy;
    logic [ST_W-1:0] mac_step;

    // position of the pixel presented now; sof forces the origin
    assign pc       = sof ? '0 : col_q;
    assign pr       = sof ? '0 : row_q;
    assign last_col = (CW'(pc) == img_width - CW'(1));
    assign win_ok   = (pc >= AW'(2)) && (pr == 2'd2);
    assign coef_arr = coefs;

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q <= '0;
            row_q <= '0;
        end else if (pix_vld) begin
            if (last_col) begin
                col_q <= '0;
                row_q <= (pr == 2'd2) ? 2'd2 : pr + 2'd1;
            end else begin
                col_q <= pc + 1'b1;
                row_q <= pr;
            end
        end
    end

    conv_linebuf #(.MAX_W(MAX_W)) i_linebuf (
        .clk     (clk),
        .wr_en   (pix_vld),
        .addr    (pc),
        .din     (pix_in),
        .col_out (lb_col)
    );

    conv_window i_window (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (pix_vld),
        .col_in    (lb_col),
        .taps      (taps),
        .right_col (right_col)
    );

    conv_mac i_mac (
        .clk     (clk),
        .rst     (rst),
        .start   (pix_vld && win_ok),
        .taps    (taps),
        .coefs   (coef_arr),
        .shamt   (shamt),
        .busy    (mac_busy),
        .step    (mac_step),
        .out_vld (out_vld),
        .out_pix (out_pix)
    );

    assign sort_col = right_col;
endmodule

// File: rtl/conv3x3_mac_chk.sv
module conv3x3_mac_chk
    import conv_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               pix_vld,
    input logic [PIX_W-1:0]   pix_in,
    input logic [3*PIX_W-1:0] sort_col,
    input logic               out_vld,
    input logic               mac_busy,
    input logic [ST_W-1:0]    mac_step
);
    logic [3:0] gap;

    always_ff @(posedge clk) begin
        if (rst)
            gap <= 4'd15;
        else if (pix_vld)
            gap <= '0;
        else if (gap != 4'd15)
            gap <= gap + 4'd1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !out_vld);

    // R9
    pixel_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        pix_vld |-> gap >= 4'd8);

    // R6
    done_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (mac_busy && mac_step == ST_W'(TAPS - 1)) |=> out_vld);

    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld |=> !out_vld);

    // R6
    strobe_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_vld) |-> $past(mac_busy));

    // R7
    sort_newest_chk: assert property (@(posedge clk) disable iff (rst)
        pix_vld |=> sort_col[PIX_W-1:0] == $past(pix_in));
endmodule

bind conv3x3_mac conv3x3_mac_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .pix_vld  (pix_vld),
    .pix_in   (pix_in),
    .sort_col (sort_col),
    .out_vld  (out_vld),
    .mac_busy (mac_busy),
    .mac_step (mac_step)
);

// File: tb/test_conv3x3_mac.sv
`timescale 1ns/1ps
module test_conv3x3_mac;
    localparam int MAX_W = 16;
    localparam int CW = $clog2(MAX_W + 1);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            sof = 1'b0;
    logic            pix_vld = 1'b0;
    logic [7:0]      pix_in = '0;
    logic [CW-1:0]   img_width = CW'(5);
    logic [71:0]     coefs = '0;
    logic [3:0]      shamt = '0;
    logic            out_vld;
    logic [7:0]      out_pix;
    logic [23:0]     sort_col;

    int checks = 0;
    int fails  = 0;
    int kern [9];
    int img [8][MAX_W];
    int out_cnt;
    bit done = 1'b0;

    always #10 clk = ~clk;

    conv3x3_mac #(.MAX_W(MAX_W)) i_conv3x3_mac (
        .clk(clk), .rst(rst), .sof(sof), .pix_vld(pix_vld), .pix_in(pix_in),
        .img_width(img_width), .coefs(coefs), .shamt(shamt),
        .out_vld(out_vld), .out_pix(out_pix), .sort_col(sort_col)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_kern(input int k0, k1, k2, k3, k4, k5, k6, k7, k8, input int sh);
        kern = '{k0, k1, k2, k3, k4, k5, k6, k7, k8};
        for (int k = 0; k < 9; k++) coefs[k*8 +: 8] = 8'(kern[k]);
        shamt = 4'(sh);
    endtask

    function automatic int model(input int r, input int c);
        int s = 0;
        for (int a = 0; a < 3; a++)
            for (int b = 0; b < 3; b++)
                s += kern[a*3 + b] * img[r-2+a][c-2+b];
        s = s >>> shamt;
        if (s < 0) s = 0;
        if (s > 255) s = 255;
        return s;
    endfunction

    // one pixel: accepted on edge E0, result checked after E9
    task automatic send(input int p, input bit first, input int r, input int c);
        bit quiet = 1'b1;
        bit want;
        @(negedge clk);
        sof = first; pix_vld = 1'b1; pix_in = 8'(p);
        @(negedge clk);
        sof = 1'b0; pix_vld = 1'b0;
        // R7 right column of window
        chk(sort_col[7:0] == 8'(p), "R7 newest", int'(sort_col[7:0]), p);
        if (r >= 1) chk(sort_col[15:8] == 8'(img[r-1][c]), "R7 one row up (R4 delay)",
                        int'(sort_col[15:8]), img[r-1][c]);
        if (r >= 2) chk(sort_col[23:16] == 8'(img[r-2][c]), "R7 two rows up (R4 delay)",
                        int'(sort_col[23:16]), img[r-2][c]);
        repeat (8) begin
            @(negedge clk);
            if (out_vld) quiet = 1'b0;
        end
        chk(quiet, "R6 no early strobe", int'(!quiet), 0);
        // after E9
        @(negedge clk);
        want = (r >= 2) && (c >= 2);
        chk(out_vld == want, "R5/R6 strobe at ninth edge", int'(out_vld), int'(want));
        if (want) begin
            out_cnt++;
            chk(out_pix == 8'(model(r, c)), "R2/R3 filtered value",
                int'(out_pix), model(r, c));
        end
    endtask

    task automatic frame(input int w, input int npix, input int seed, input bit count_chk);
        img_width = CW'(w);
        out_cnt = 0;
        for (int i = 0; i < npix; i++) begin
            int r = i / w;
            int c = i % w;
            int p = (r*53 + c*29 + seed*17 + r*c*7 + ((seed & 1) ? c*c*5 : 0)) & 255;
            img[r][c] = p;
            send(p, i == 0, r, c);
        end
        if (count_chk) begin
            int h = npix / w;
            chk(out_cnt == (h-2)*(w-2), "R5 result count", out_cnt, (h-2)*(w-2));
        end
    endtask

    initial begin
        #4000000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(out_vld == 1'b0, "R1 strobe in reset", int'(out_vld), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_vld == 1'b0 && out_pix == 8'd0, "R1 after reset", int'(out_pix), 0);

        // identity kernel: result is centre pixel
        set_kern(0,0,0, 0,1,0, 0,0,0, 0);
        frame(5, 20, 1, 1);
        // asymmetric kernel checks tap ordering, negative sums clamp
        set_kern(-4,-3,-2, -1,0,1, 2,3,4, 1);
        frame(3, 12, 2, 1);
        // averaging, R3 shift
        set_kern(1,1,1, 1,1,1, 1,1,1, 3);
        frame(9, 45, 3, 1);
        // high-pass, saturates both ways
        set_kern(-1,-1,-1, -1,8,-1, -1,-1,-1, 0);
        frame(MAX_W, 4*MAX_W, 4, 1);
        // smoothing with larger shift
        set_kern(1,2,1, 2,4,2, 1,2,1, 4);
        frame(7, 28, 5, 1);
        // extreme coefficients, large positive sums
        set_kern(127,-128,127, 5,127,-7, 9,11,127, 2);
        frame(4, 16, 6, 1);
        // R8: abandon a frame mid-row, restart at a different width
        set_kern(3,0,-1, 2,1,0, -2,5,1, 1);
        frame(6, 9, 7, 0);
        frame(4, 20, 8, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule